// File: doc/BRIEF.md
# ASID-Tagged Translation Cache with Selective Invalidation

This block is a small fully associative cache of page translations. Each line holds an address-space identifier, a virtual page number, a physical frame number and a permission field. A client presents an identifier and page number, and one cycle later the block answers with a hit and its frame and permissions, or with a miss. The first miss raises a one-cycle walk request and leaves a walk outstanding. An external walker then returns the translation on the fill port, and the block stores it in a line.

Invalidation is driven by writes of a 32-bit command word. The low two bits choose the scope: every entry, one 4 MiB section or one 16 KiB group. The top bit, when set, restricts the command to a single identifier. A 32-bit configuration word sets how many lines are in use. It also sets whether lookups may continue while a walk is outstanding (hit-under-miss). When that is off, lookups stall until the fill arrives.

Top module: `asid_tlb`

## Requirements
- R1: After reset no line is valid, `lk_ready` is 1, `rsp_valid` and `walk_req` are 0, hit-under-miss is off and all LINES lines are in use.
- R2: A lookup accepted at a clock edge (`lk_valid` and `lk_ready`) gives `rsp_valid` after that edge. `rsp_hit` is 1 only when an in-use valid line matches both `lk_asid` and `lk_vpn`, and then `rsp_pfn` and `rsp_perm` carry that line's contents. The same page under a different identifier misses.
- R3: An accepted lookup that misses while no walk is outstanding raises `walk_req` for one cycle, together with its `rsp_valid`, and shows the identifier and page on `walk_asid`/`walk_vpn`. The walk stays outstanding until any `fill_valid` cycle, including a fill that is dropped.
- R4: With hit-under-miss off and a walk outstanding, `lk_ready` is 0 and no lookup is answered.
- R5: With hit-under-miss on, `lk_ready` stays 1 while a walk is outstanding. Hits are answered normally. Misses are answered with `rsp_hit` 0 and start no second walk.
- R6: A fill whose tag is not already present is written to the line chosen by a round-robin pointer. The pointer starts at line 0 and wraps at the in-use count.
- R7: A fill whose identifier and page match a valid in-use line rewrites that line and leaves the pointer unchanged, so a tag is never held twice.
- R8: Command bits 1:0 = 0 invalidate every line. When bit 31 is 1, only lines whose identifier equals bits 30:24 are invalidated. This identifier qualifier applies to every scope.
- R9: Command bits 1:0 = 2 invalidate the lines whose page-number bits 19:10 equal command bits 19:10 (a 4 MiB section).
- R10: Command bits 1:0 = 3 invalidate the lines whose page-number bits 19:2 equal command bits 19:2 (a 16 KiB group). Bits 1:0 = 1 invalidate nothing.
- R11: An invalidation takes effect after its write edge. A lookup in the write cycle still sees the old contents. A fill in that cycle that the command matches is dropped, and a fill that it does not match is stored.
- R12: A configuration write sets hit-under-miss from bit 29 and the in-use count from the low bits masked by 2*LINES-1. A masked value of 0 or above LINES selects LINES. Lines at or above the new count are invalidated, and only lines below the count are searched or replaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration word: bit 29 hit-under-miss, low bits in-use count |
| flush_we | input | 1 | Invalidation command write strobe |
| flush_wdata | input | 32 | Invalidation command: scope, identifier qualifier, address |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | 7 | Lookup address-space identifier |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| rsp_valid | output | 1 | Lookup answer valid |
| rsp_hit | output | 1 | Lookup answer is a hit |
| rsp_pfn | output | PFN_W | Frame number of the hit |
| rsp_perm | output | PERM_W | Permissions of the hit |
| walk_req | output | 1 | One-cycle request to walk the page tables |
| walk_asid | output | 7 | Identifier to walk |
| walk_vpn | output | 20 | Page number to walk |
| fill_valid | input | 1 | Walk result strobe |
| fill_asid | input | 7 | Walk result identifier |
| fill_vpn | input | 20 | Walk result page number |
| fill_pfn | input | PFN_W | Walk result frame number |
| fill_perm | input | PERM_W | Walk result permissions |

## Verification
A stale valid bit left behind by a missed invalidation or trim appears one cycle later as a wrong `rsp_hit`. A bad pointer or same-tag search shows up as a translation that should survive but misses at its next lookup. A wrong outstanding-walk flag shows at once on `lk_ready` when hit-under-miss is off, or as a missing or extra `walk_req`. The bench holds a behavioural model of the lines and compares the answer, walk request and ready signal after every edge, so a divergence is reported in the cycle it reaches a port.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int ASID_W = 7;
  localparam int VPN_W  = 20;

  typedef enum logic [1:0] {
    SCOPE_ALL   = 2'd0,
    SCOPE_NONE  = 2'd1,
    SCOPE_SECT  = 2'd2,
    SCOPE_GROUP = 2'd3
  } scope_e;

  typedef struct packed {
    logic              asid_en;
    logic [ASID_W-1:0] asid;
    scope_e            scope;
    logic [17:0]       page_hi;  // page-number bits 19:2
  } inval_cmd_t;

  function automatic inval_cmd_t inval_decode(input logic [31:0] w);
    inval_cmd_t c;
    c.asid_en = w[31];
    c.asid    = w[30:24];
    c.scope   = scope_e'(w[1:0]);
    c.page_hi = w[19:2];
    return c;
  endfunction

  function automatic logic inval_match(input inval_cmd_t c,
                                       input logic [ASID_W-1:0] a,
                                       input logic [VPN_W-1:0] v);
    logic id_ok;
    logic pg_ok;
    id_ok = !c.asid_en || (a == c.asid);
    case (c.scope)
      SCOPE_ALL:   pg_ok = 1'b1;
      SCOPE_SECT:  pg_ok = (v[19:10] == c.page_hi[17:8]);
      SCOPE_GROUP: pg_ok = (v[19:2] == c.page_hi);
      default:     pg_ok = 1'b0;
    endcase
    return id_ok && pg_ok;
  endfunction
endpackage

// File: rtl/tlb_lines.sv
module tlb_lines
  import tlb_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int PFN_W  = 20,
  parameter int PERM_W = 3,
  parameter int IDX_W  = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINES-1:0]  act_mask,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic [LINES-1:0]  hit_vec,
  output logic [PFN_W-1:0]  rd_pfn,
  output logic [PERM_W-1:0] rd_perm,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [VPN_W-1:0]  wr_vpn,
  output logic [LINES-1:0]  same_vec,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic              inval_en,
  input  inval_cmd_t        inval_cmd,
  input  logic              trim_en,
  input  logic [LINES-1:0]  keep_mask
);
  logic [LINES-1:0]  valid_q;
  logic [ASID_W-1:0] asid_q [LINES];
  logic [VPN_W-1:0]  vpn_q  [LINES];
  logic [PFN_W-1:0]  pfn_q  [LINES];
  logic [PERM_W-1:0] perm_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (wr_en && wr_idx == IDX_W'(i))
          valid_q[i] <= 1'b1;
        else if ((inval_en && inval_match(inval_cmd, asid_q[i], vpn_q[i])) ||
                 (trim_en && !keep_mask[i]))
          valid_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      asid_q[wr_idx] <= wr_asid;
      vpn_q[wr_idx]  <= wr_vpn;
      pfn_q[wr_idx]  <= wr_pfn;
      perm_q[wr_idx] <= wr_perm;
    end
  end

  always_comb begin
    rd_pfn  = '0;
    rd_perm = '0;
    for (int i = 0; i < LINES; i++) begin
      hit_vec[i]  = valid_q[i] && act_mask[i] &&
                    asid_q[i] == lk_asid && vpn_q[i] == lk_vpn;
      same_vec[i] = valid_q[i] && act_mask[i] &&
                    asid_q[i] == wr_asid && vpn_q[i] == wr_vpn;
      if (hit_vec[i]) begin
        rd_pfn  = rd_pfn | pfn_q[i];
        rd_perm = rd_perm | perm_q[i];
      end
    end
  end

  // R7
  hit_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  // R8
  inval_all_chk: assert property (@(posedge clk) disable iff (rst)
    (inval_en && inval_cmd.scope == SCOPE_ALL && !inval_cmd.asid_en && !wr_en)
    |=> (valid_q == '0));
endmodule

// File: rtl/tlb_rr.sv
module tlb_rr #(
  parameter int LINES = 8,
  parameter int IDX_W = $clog2(LINES),
  parameter int CNT_W = $clog2(LINES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] act_n,
  input  logic             adv,
  output logic [IDX_W-1:0] victim
);
  logic [IDX_W-1:0] ptr_q;
  logic [CNT_W-1:0] nxt;

  assign victim = (CNT_W'(ptr_q) >= act_n) ? '0 : ptr_q;
  assign nxt    = CNT_W'(victim) + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)
      ptr_q <= '0;
    else if (adv)
      ptr_q <= (nxt >= act_n) ? '0 : IDX_W'(nxt);
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int PFN_W  = 20,
  parameter int PERM_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  input  logic              flush_we,
  input  logic [31:0]       flush_wdata,
  input  logic              lk_valid,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PFN_W-1:0]  rsp_pfn,
  output logic [PERM_W-1:0] rsp_perm,
  output logic              walk_req,
  output logic [ASID_W-1:0] walk_asid,
  output logic [VPN_W-1:0]  walk_vpn,
  input  logic              fill_valid,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [PERM_W-1:0] fill_perm
);
  localparam int IDX_W = $clog2(LINES);
  localparam int CNT_W = $clog2(LINES + 1);
  localparam int MSK_W = $clog2(2 * LINES);
  localparam logic [MSK_W-1:0] CNT_MASK = MSK_W'(2 * LINES - 1);

  logic             hum_q, pend_q;
  logic [CNT_W-1:0] act_q;

  // configuration decode
  logic [MSK_W-1:0] cfg_cnt;
  logic [CNT_W-1:0] cfg_act;
  logic             unused_cfg;
  assign cfg_cnt    = cfg_wdata[MSK_W-1:0] & CNT_MASK;
  assign cfg_act    = (cfg_cnt == '0 || int'(cfg_cnt) > LINES) ? CNT_W'(LINES) : CNT_W'(cfg_cnt);
  assign unused_cfg = ^{cfg_wdata[31:30], cfg_wdata[28:MSK_W], flush_wdata[23:20]};

  logic [LINES-1:0] act_mask, keep_mask;
  always_comb begin
    for (int i = 0; i < LINES; i++) begin
      act_mask[i]  = CNT_W'(i) < act_q;
      keep_mask[i] = CNT_W'(i) < cfg_act;
    end
  end

  // invalidation command and fill drop
  inval_cmd_t icmd;
  logic       fill_drop;
  assign icmd      = inval_decode(flush_wdata);
  assign fill_drop = flush_we && inval_match(icmd, fill_asid, fill_vpn);

  logic [LINES-1:0]  hit_vec, same_vec;
  logic [PFN_W-1:0]  rd_pfn;
  logic [PERM_W-1:0] rd_perm;
  logic [IDX_W-1:0]  victim, same_idx, wr_idx;
  logic              same_any, wr_en, adv;

  always_comb begin
    same_idx = '0;
    for (int i = 0; i < LINES; i++)
      if (same_vec[i]) same_idx = IDX_W'(i);
  end

  assign same_any = |same_vec;
  assign wr_en    = fill_valid && !fill_drop;
  assign wr_idx   = same_any ? same_idx : victim;
  assign adv      = wr_en && !same_any;

  tlb_lines #(.LINES(LINES), .PFN_W(PFN_W), .PERM_W(PERM_W), .IDX_W(IDX_W)) u_lines (
    .clk(clk), .rst(rst), .act_mask(act_mask),
    .lk_asid(lk_asid), .lk_vpn(lk_vpn),
    .hit_vec(hit_vec), .rd_pfn(rd_pfn), .rd_perm(rd_perm),
    .wr_asid(fill_asid), .wr_vpn(fill_vpn), .same_vec(same_vec),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_pfn(fill_pfn), .wr_perm(fill_perm),
    .inval_en(flush_we), .inval_cmd(icmd),
    .trim_en(cfg_we), .keep_mask(keep_mask)
  );

  tlb_rr #(.LINES(LINES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_rr (
    .clk(clk), .rst(rst), .act_n(act_q), .adv(adv), .victim(victim)
  );

  // lookup control
  logic acc, hit_any, start;
  assign lk_ready = !pend_q || hum_q;
  assign acc      = lk_valid && lk_ready;
  assign hit_any  = |hit_vec;
  assign start    = acc && !hit_any && !pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pfn   <= '0;
      rsp_perm  <= '0;
      walk_req  <= 1'b0;
      walk_asid <= '0;
      walk_vpn  <= '0;
      pend_q    <= 1'b0;
      hum_q     <= 1'b0;
      act_q     <= CNT_W'(LINES);
    end else begin
      rsp_valid <= acc;
      rsp_hit   <= acc && hit_any;
      if (acc) begin
        rsp_pfn  <= rd_pfn;
        rsp_perm <= rd_perm;
      end
      walk_req <= start;
      if (start) begin
        walk_asid <= lk_asid;
        walk_vpn  <= lk_vpn;
      end
      if (start)           pend_q <= 1'b1;
      else if (fill_valid) pend_q <= 1'b0;
      if (cfg_we) begin
        hum_q <= cfg_wdata[29];
        act_q <= cfg_act;
      end
    end
  end

  // R3
  walk_is_miss_chk: assert property (@(posedge clk) disable iff (rst)
    walk_req |-> (rsp_valid && !rsp_hit));

  // R3
  fill_ends_walk_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && pend_q) |=> !pend_q);
endmodule

// File: tb/tb_asid_tlb.sv
module tb_asid_tlb;
  localparam int LINES  = 8;
  localparam int PFN_W  = 20;
  localparam int PERM_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0, flush_we = 1'b0, lk_valid = 1'b0, fill_valid = 1'b0;
  logic [31:0] cfg_wdata = '0, flush_wdata = '0;
  logic [6:0]  lk_asid = '0, fill_asid = '0;
  logic [19:0] lk_vpn = '0, fill_vpn = '0;
  logic [PFN_W-1:0]  fill_pfn = '0;
  logic [PERM_W-1:0] fill_perm = '0;
  logic lk_ready, rsp_valid, rsp_hit, walk_req;
  logic [PFN_W-1:0]  rsp_pfn;
  logic [PERM_W-1:0] rsp_perm;
  logic [6:0]  walk_asid;
  logic [19:0] walk_vpn;

  always #5 clk = ~clk;

  asid_tlb #(.LINES(LINES), .PFN_W(PFN_W), .PERM_W(PERM_W)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .flush_we(flush_we), .flush_wdata(flush_wdata),
    .lk_valid(lk_valid), .lk_asid(lk_asid), .lk_vpn(lk_vpn), .lk_ready(lk_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pfn(rsp_pfn), .rsp_perm(rsp_perm),
    .walk_req(walk_req), .walk_asid(walk_asid), .walk_vpn(walk_vpn),
    .fill_valid(fill_valid), .fill_asid(fill_asid), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_perm(fill_perm)
  );

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    done = 0;

  // behavioural reference
  bit mv[LINES];
  int ma[LINES], mvp[LINES], mpf[LINES], mpm[LINES];
  int mptr = 0, mact = LINES;
  bit mhum = 0, mpend = 0;
  bit e_rv = 0, e_hit = 0, e_walk = 0, e_ready = 1;
  int e_pfn = 0, e_perm = 0, e_wa = 0, e_wv = 0;

  task automatic chk(string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", cur_req, what, got, exp);
    end
  endtask

  function automatic bit cmd_hits(logic [31:0] w, int a, int v);
    if (w[31] && a != int'(w[30:24])) return 0;
    case (w[1:0])
      2'd0: return 1;
      2'd2: return (v >> 10) == ((int'(w) >> 10) & 'h3FF);
      2'd3: return (v >> 2) == ((int'(w) >> 2) & 'h3FFFF);
      default: return 0;
    endcase
  endfunction

  task automatic model_step();
    bit ready, acc, hit, drop, start;
    int hi, same, v, na;
    ready = !mpend || mhum;
    acc = lk_valid && ready;
    hit = 0; hi = 0;
    for (int i = 0; i < mact; i++)
      if (mv[i] && ma[i] == int'(lk_asid) && mvp[i] == int'(lk_vpn)) begin hit = 1; hi = i; end
    e_rv = acc; e_hit = acc && hit; e_pfn = mpf[hi]; e_perm = mpm[hi];
    start = acc && !hit && !mpend;
    e_walk = start;
    if (start) begin e_wa = int'(lk_asid); e_wv = int'(lk_vpn); end
    drop = flush_we && cmd_hits(flush_wdata, int'(fill_asid), int'(fill_vpn));
    same = -1;
    for (int i = 0; i < mact; i++)
      if (mv[i] && ma[i] == int'(fill_asid) && mvp[i] == int'(fill_vpn)) same = i;
    if (flush_we)
      for (int i = 0; i < LINES; i++)
        if (mv[i] && cmd_hits(flush_wdata, ma[i], mvp[i])) mv[i] = 0;
    if (fill_valid && !drop) begin
      v = (mptr >= mact) ? 0 : mptr;
      if (same >= 0) v = same;
      else mptr = (v + 1 >= mact) ? 0 : v + 1;
      mv[v] = 1; ma[v] = int'(fill_asid); mvp[v] = int'(fill_vpn);
      mpf[v] = int'(fill_pfn); mpm[v] = int'(fill_perm);
    end
    if (cfg_we) begin
      na = int'(cfg_wdata[3:0]) & (2 * LINES - 1);
      if (na == 0 || na > LINES) na = LINES;
      mact = na; mhum = cfg_wdata[29];
      for (int i = na; i < LINES; i++) mv[i] = 0;
    end
    if (start) mpend = 1;
    else if (fill_valid) mpend = 0;
    e_ready = !mpend || mhum;
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk("lk_ready", int'(lk_ready), int'(e_ready));
    chk("rsp_valid", int'(rsp_valid), int'(e_rv));
    chk("walk_req", int'(walk_req), int'(e_walk));
    if (e_rv) chk("rsp_hit", int'(rsp_hit), int'(e_hit));
    if (e_hit) begin
      chk("rsp_pfn", int'(rsp_pfn), e_pfn);
      chk("rsp_perm", int'(rsp_perm), e_perm);
    end
    if (e_walk) begin
      chk("walk_asid", int'(walk_asid), e_wa);
      chk("walk_vpn", int'(walk_vpn), e_wv);
    end
  endtask

  task automatic lookup(int a, int v);
    lk_valid = 1; lk_asid = 7'(a); lk_vpn = 20'(v);
    tick();
    lk_valid = 0;
  endtask

  task automatic fill(int a, int v, int p, int pm);
    fill_valid = 1; fill_asid = 7'(a); fill_vpn = 20'(v);
    fill_pfn = PFN_W'(p); fill_perm = PERM_W'(pm);
    tick();
    fill_valid = 0;
  endtask

  task automatic inval(logic [31:0] w);
    flush_we = 1; flush_wdata = w;
    tick();
    flush_we = 0;
  endtask

  task automatic config_write(logic [31:0] w);
    cfg_we = 1; cfg_wdata = w;
    tick();
    cfg_we = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  localparam logic [31:0] HUM = 32'h2000_0000;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    cur_req = "R1";
    chk("lk_ready", int'(lk_ready), 1);
    chk("rsp_valid", int'(rsp_valid), 0);
    chk("walk_req", int'(walk_req), 0);
    lookup(5, 'h12345);

    cur_req = "R2";
    fill(5, 'h12345, 'hABCDE, 5);
    lookup(5, 'h12345);
    cur_req = "R3";
    lookup(6, 'h12345);
    cur_req = "R4";
    lookup(5, 'h12345);
    tick();
    cur_req = "R3";
    fill(6, 'h12345, 'h11111, 3);
    lookup(6, 'h12345);
    cur_req = "R2";
    lookup(7, 'h12345);
    fill(7, 'h12345, 'h33333, 1);

    cur_req = "R5";
    config_write(HUM | 32'd8);
    lookup(1, 'h1);
    lookup(5, 'h12345);
    lookup(2, 'h2);
    fill(1, 'h1, 'h22222, 7);
    lookup(1, 'h1);

    cur_req = "R6";
    for (int i = 0; i < 4; i++) fill(3, 'h100 + i, 'h40000 + i, i);
    fill(3, 'h200, 'h50000, 2);
    lookup(5, 'h12345);
    lookup(6, 'h12345);
    lookup(3, 'h103);
    fill(3, 'h201, 'h50001, 2);

    cur_req = "R7";
    fill(3, 'h200, 'h60000, 6);
    fill(4, 'h300, 'h70000, 4);
    lookup(3, 'h200);
    lookup(6, 'h12345);
    lookup(4, 'h300);

    cur_req = "R8";
    inval(32'h0);
    lookup(3, 'h200);
    lookup(1, 'h1);
    fill(1, 'h400, 'h1, 1); fill(1, 'h404, 'h2, 2); fill(2, 'h400, 'h3, 3);
    fill(1, 'h800, 'h4, 4); fill(2, 'hC01, 'h5, 5); fill(1, 'h401, 'h6, 6);
    inval(32'h8000_0000 | (32'd2 << 24));
    lookup(2, 'h400); lookup(2, 'hC01); lookup(1, 'h400); lookup(1, 'h800);

    cur_req = "R9";
    fill(2, 'h400, 'h3, 3);
    inval(32'h8000_0000 | (32'd1 << 24) | (32'd1 << 10) | 32'd2);
    lookup(1, 'h400); lookup(1, 'h404); lookup(1, 'h401);
    lookup(1, 'h800); lookup(2, 'h400);

    cur_req = "R10";
    fill(1, 'h400, 'h7, 1); fill(1, 'h404, 'h8, 2); fill(1, 'h401, 'h9, 3);
    inval(32'h0000_0400 | 32'd3);
    lookup(1, 'h400); lookup(1, 'h401); lookup(2, 'h400);
    lookup(1, 'h404); lookup(1, 'h800);
    inval(32'h0000_0404 | 32'd1);
    lookup(1, 'h404);

    cur_req = "R11";
    flush_we = 1; flush_wdata = 32'h8000_0000 | (32'd1 << 24);
    lk_valid = 1; lk_asid = 7'd1; lk_vpn = 20'h404;
    fill_valid = 1; fill_asid = 7'd1; fill_vpn = 20'h500; fill_pfn = 'h123; fill_perm = 3'd1;
    tick();
    flush_we = 0; lk_valid = 0; fill_valid = 0;
    lookup(1, 'h404);
    lookup(1, 'h500);
    flush_we = 1; flush_wdata = 32'h8000_0000 | (32'd1 << 24);
    fill_valid = 1; fill_asid = 7'd2; fill_vpn = 20'h600; fill_pfn = 'h456; fill_perm = 3'd2;
    tick();
    flush_we = 0; fill_valid = 0;
    lookup(2, 'h600);
    lookup(2, 'hC01);

    cur_req = "R12";
    config_write(HUM | 32'd3);
    lookup(2, 'h600); lookup(2, 'hC01);
    for (int i = 0; i < 5; i++) fill(6, 'h900 + i, 'h900 + i, i);
    for (int i = 0; i < 5; i++) lookup(6, 'h900 + i);
    config_write(HUM | 32'd0);
    lookup(6, 'h903);
    for (int i = 0; i < 6; i++) fill(6, 'hA00 + i, 'hA00 + i, i);
    for (int i = 0; i < 6; i++) lookup(6, 'hA00 + i);
    config_write(HUM | 32'd20);
    for (int i = 0; i < 6; i++) lookup(6, 'hA00 + i);
    config_write(HUM | 32'h1F);
    fill(6, 'hB00, 'hB00, 1);
    lookup(6, 'hB00);
    config_write(32'd4);
    lookup(7, 'h7);
    lookup(6, 'hB00);
    fill(7, 'h7, 'h777, 7);
    lookup(7, 'h7);
    tick();

    done = 1;
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL %s watchdog: got timeout expected completion", cur_req);
      finish_run();
    end
  end
endmodule